// File: doc/BRIEF.md
# Triple-Redundant Windowed Pulse Counter

This block counts pulses from eight asynchronous converter outputs over a fixed acquisition window and hands a total for each channel to the framing logic downstream. Every pulse input first passes through one register on the system clock. A rising edge on that registered signal then counts as one pulse. A free-running window timer marks the last cycle of each window. In that cycle the running count of every channel moves to a held total, and the running count restarts with no dead time.

All state that decides whether the machine is protected is kept in three copies. This covers the running counts, the held totals, the window timer and the reset that clears them. A bitwise two-of-three vote gives the value the logic uses. Every copy is rewritten each cycle from that voted value, so a single upset in one copy is overwritten at the next clock. The input synchroniser and edge detector are single copies. The held totals are a plain output that is refreshed once per window, and a one-cycle strobe marks each refresh. The window cannot stall, so this edge has no valid/ready handshake and no back-pressure: a consumer that misses the strobe can still read the same totals until the next strobe.

Top module: `tmr_pulse_window_counter`

## Requirements
- R1: Each `pulse_in` bit is registered once on `clk` and then edge-detected. A 0-to-1 transition adds exactly one count. Holding the input high adds nothing further. A rising edge set up before clock edge n is counted at clock edge n+1.
- R2: With the voted reset released at clock edge E0, `win_done` is high for exactly one cycle after edges E(k·WIN_CYCLES), k ≥ 1, and low after every other edge.
- R3: After each `win_done` edge, `win_count[ch*CNT_W +: CNT_W]` holds the number of rising edges counted on channel ch in the window that just ended. The value stays unchanged until the next `win_done` edge.
- R4: A rising edge counted on the clock edge that closes a window goes into the new window. No pulse is lost or counted twice across a boundary.
- R5: A channel total saturates at 2^CNT_W − 1 and never wraps.
- R6: The channels are independent. Activity on one channel never changes another channel's total.
- R7: While `rst_n` is low, the three reset copies are asserted at once. From the first clock edge with the voted reset asserted, all totals read 0 and `win_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases on the clock |
| pulse_in | input | N_CH | Asynchronous converter pulse lines, one per channel |
| win_done | output | 1 | One-cycle strobe: new totals are present |
| win_count | output | N_CH*CNT_W | Voted window totals, channel ch at bits ch*CNT_W +: CNT_W |

## Verification
The bench builds the block with a 16-cycle window and 3-bit counters and keeps eight channels. With these values, dozens of complete windows fit in a few hundred cycles, and a channel that toggles every cycle reaches saturation within one window. Every cycle of every window is compared, and the stimulus rotates through dense toggling, sparse one-cycle pulses, held-high levels, silence and pulses placed next to the window boundary. A second run after a mid-window reset checks that the totals clear and that the window phase restarts from the release edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCOPY = 3;
  localparam int unsigned DEF_N_CH = 8;
  localparam int unsigned DEF_CNT_W = 20;
  localparam int unsigned DEF_WIN_CYCLES = 1600;
endpackage

// File: rtl/pc_input_stage.sv
module pc_input_stage #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_v,
  input  logic [N_CH-1:0] pulse_in,
  output logic [N_CH-1:0] rise
);
  logic [N_CH-1:0] in_q;
  logic [N_CH-1:0] last_q;

  // one register on the raw inputs, nothing ahead of it
  always_ff @(posedge clk) begin
    if (rst_v) begin
      in_q   <= '0;
      last_q <= '0;
    end else begin
      in_q   <= pulse_in;
      last_q <= in_q;
    end
  end

  assign rise = in_q & ~last_q;

  // R1: a counted edge cannot repeat on the next cycle
  p_single_edge_r1: assert property (@(posedge clk) disable iff (rst_v)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/pc_window_timer.sv
module pc_window_timer
  import tmr_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 1600
) (
  input  logic clk,
  input  logic rst_v,
  output logic boundary,
  output logic done
);
  localparam int unsigned TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam int unsigned GW = $clog2(WIN_CYCLES + 1) + 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [NCOPY-1:0][TW-1:0] t_q;
  logic [TW-1:0] t_v;
  logic [TW-1:0] t_nx;

  assign t_v = (t_q[0] & t_q[1]) | (t_q[0] & t_q[2]) | (t_q[1] & t_q[2]);
  assign boundary = (t_v == LAST);
  assign t_nx = boundary ? '0 : t_v + 1'b1;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCOPY; i++) begin
      t_q[i] <= rst_v ? '0 : t_nx;
    end
    done <= rst_v ? 1'b0 : boundary;
  end

  // checker: cycles since last strobe or reset
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst_v) gap_q <= '0;
    else       gap_q <= done ? GW'(1) : gap_q + 1'b1;
  end

  p_period_r2: assert property (@(posedge clk) disable iff (rst_v)
    done |-> (gap_q == GW'(WIN_CYCLES)));
  p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst_v)
    gap_q <= GW'(WIN_CYCLES));
  p_strobe_one_r2: assert property (@(posedge clk) disable iff (rst_v)
    done |=> !done);
endmodule

// File: rtl/pc_tmr_channel.sv
module pc_tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_v,
  input  logic             boundary,
  input  logic             inc,
  output logic [CNT_W-1:0] total
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [NCOPY-1:0][CNT_W-1:0] run_q;
  logic [NCOPY-1:0][CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] run_v;
  logic [CNT_W-1:0] run_nx;

  assign run_v = (run_q[0] & run_q[1]) | (run_q[0] & run_q[2]) | (run_q[1] & run_q[2]);
  assign total = (tot_q[0] & tot_q[1]) | (tot_q[0] & tot_q[2]) | (tot_q[1] & tot_q[2]);

  // edge in the boundary cycle opens the new window
  always_comb begin
    if (boundary)          run_nx = {{(CNT_W-1){1'b0}}, inc};
    else if (run_v == TOP) run_nx = TOP;
    else                   run_nx = run_v + {{(CNT_W-1){1'b0}}, inc};
  end

  // every copy rewritten from the vote: scrubbing each cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < NCOPY; i++) begin
      if (rst_v) begin
        run_q[i] <= '0;
        tot_q[i] <= '0;
      end else begin
        run_q[i] <= run_nx;
        tot_q[i] <= boundary ? run_v : total;
      end
    end
  end

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst_v)
    !boundary |=> (run_v >= $past(run_v)));
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst_v)
    (!boundary && run_v == TOP) |=> (run_v == TOP));
  p_total_hold_r3: assert property (@(posedge clk) disable iff (rst_v)
    !boundary |=> $stable(total));
  p_restart_r4: assert property (@(posedge clk) disable iff (rst_v)
    boundary |=> (run_v <= CNT_W'(1)));
endmodule

// File: rtl/tmr_pulse_window_counter.sv
module tmr_pulse_window_counter
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH       = DEF_N_CH,
  parameter int unsigned CNT_W      = DEF_CNT_W,
  parameter int unsigned WIN_CYCLES = DEF_WIN_CYCLES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       pulse_in,
  output logic                  win_done,
  output logic [N_CH*CNT_W-1:0] win_count
);
  // triplicated reset: async assert, clocked release, voted
  logic [NCOPY-1:0] rst_q;
  logic rst_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '1;
    else        rst_q <= '0;
  end

  assign rst_v = (rst_q[0] & rst_q[1]) | (rst_q[0] & rst_q[2]) | (rst_q[1] & rst_q[2]);

  logic [N_CH-1:0] rise;
  logic boundary;

  pc_input_stage #(.N_CH(N_CH)) u_in (
    .clk(clk), .rst_v(rst_v), .pulse_in(pulse_in), .rise(rise)
  );

  pc_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_tmr (
    .clk(clk), .rst_v(rst_v), .boundary(boundary), .done(win_done)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pc_tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_v(rst_v), .boundary(boundary), .inc(rise[ch]),
      .total(win_count[ch*CNT_W +: CNT_W])
    );
  end

  p_reset_clear_r7: assert property (@(posedge clk)
    rst_v |=> (win_count == '0 && !win_done));
endmodule

// File: tb/tb_tmr_pulse_window_counter.sv
module tb_tmr_pulse_window_counter;
  localparam int NCH = 8;
  localparam int CW  = 3;
  localparam int WIN = 16;
  localparam int NWIN = 12;
  localparam int SATV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] pulse_in;
  logic win_done;
  logic [NCH*CW-1:0] win_count;

  int n_chk = 0;
  int n_bad = 0;
  int expc [0:NWIN+2][0:NCH-1];
  int held [0:NCH-1];
  bit prv [0:NCH-1];

  always #10 clk = ~clk;

  tmr_pulse_window_counter #(.N_CH(NCH), .CNT_W(CW), .WIN_CYCLES(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .win_done(win_done), .win_count(win_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit drv(input int c, input int ch, input int run);
    int w;
    int mode;
    w = c / WIN;
    mode = (w + run) % 4;
    case (mode)
      0: return bit'((c >> (ch % 3)) & 1);
      1: return (ch == 7) ? 1'b1 : bit'(((c + ch) % (ch + 2)) == 0);
      2: return 1'b0;
      default: return bit'(((c % WIN == WIN-1) || (c % WIN == WIN-3)) && (ch % 2 == 1));
    endcase
  endfunction

  task automatic run_windows(input int run);
    for (int w = 0; w <= NWIN + 2; w++)
      for (int ch = 0; ch < NCH; ch++) expc[w][ch] = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      prv[ch] = 1'b0;
      held[ch] = 0;
    end
    for (int c = 1; c <= NWIN * WIN + 1; c++) begin
      int k;
      @(negedge clk);
      k = c - 1;
      if (k > 0 && k % WIN == 0) begin
        chk(win_done == 1'b1, "R2 strobe at window end", int'(win_done), 1);
        for (int ch = 0; ch < NCH; ch++) begin
          int e;
          e = (expc[k/WIN - 1][ch] > SATV) ? SATV : expc[k/WIN - 1][ch];
          held[ch] = e;
          // R3 R4 R5 R6: per-channel total of the closed window
          chk(int'(win_count[ch*CW +: CW]) == e, "R3/R4/R5/R6 window total",
              int'(win_count[ch*CW +: CW]), e);
        end
      end else begin
        chk(win_done == 1'b0, "R2 no strobe mid-window", int'(win_done), 0);
        for (int ch = 0; ch < NCH; ch++)
          chk(int'(win_count[ch*CW +: CW]) == held[ch], "R3 total held",
              int'(win_count[ch*CW +: CW]), held[ch]);
      end
      for (int ch = 0; ch < NCH; ch++) begin
        bit v;
        v = drv(c, ch, run);
        pulse_in[ch] = v;
        // R1: only a 0-to-1 change counts, landing one edge later
        if (v && !prv[ch] && ((c + 1) / WIN) <= NWIN + 2)
          expc[(c + 1) / WIN][ch]++;
        prv[ch] = v;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pulse_in = '0;
    @(negedge clk);
    @(negedge clk);
    chk(win_count == '0, "R7 totals cleared in reset", int'(win_count), 0);
    chk(win_done == 1'b0, "R7 strobe low in reset", int'(win_done), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    pulse_in = '0;
    repeat (3) @(negedge clk);
    chk(win_count == '0, "R7 reset state", int'(win_count), 0);
    chk(win_done == 1'b0, "R7 reset strobe", int'(win_done), 0);
    rst_n = 1'b1;
    run_windows(0);
    // reset in the middle of a window, then a second run with shifted modes
    repeat (5) begin
      @(negedge clk);
      pulse_in = ~pulse_in;
    end
    do_reset();
    run_windows(1);
    do_reset();
    run_windows(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule